// File: doc/BRIEF.md
# Serial Slave Front End with Hold

This block is the bit-level front end of a serial memory slave. It runs on a fast system clock and oversamples four pins: chip select, serial clock, data in and an active-low hold pin. Each pin passes through a synchronizer. Bytes arriving on the data input are assembled most significant bit first on the serial clock rising edge. Each complete byte is presented with a one-cycle valid strobe for downstream command logic. A response byte supplied by that logic is shifted out on the data output, changing on the serial clock falling edge (clock idles low).

The hold pin pauses a transfer in the middle of a byte without losing its place. Hold takes effect only while the serial clock is low. If the pin changes while the clock is high, the change is deferred until the clock next falls. During a pause, clock and data activity is ignored and the output driver is released. Deselecting during a pause wipes the interface. A new pause then needs the hold pin to be seen high first.

A busy indication from the internal write, program and erase logic is carried through one register. A pause has no effect on it.

Top module: `serial_hold_frontend`

## Requirements
- R1: Input bits are taken on each serial clock rising edge, most significant bit first. After every eighth bit, `rx_byte_o` shows the byte and `byte_valid_o` is high for exactly one system clock cycle.
- R2: At selection, `tx_byte_i` is loaded into the output shifter, and it is loaded again on the falling edge that follows each completed byte. Its bits leave MSB first on `miso_o`, advancing on each serial clock falling edge. `miso_oe_o` is 1 while selected and not held.
- R3: A hold pin low while selected and the serial clock low starts the pause (`hold_active_o`=1) within a few system cycles.
- R4: If the hold pin goes low while the serial clock is high, `hold_active_o` stays 0 until the serial clock goes low.
- R5: Releasing the hold pin ends the pause while the serial clock is low. If the clock is high at release, the pause lasts until the clock next goes low.
- R6: During a pause, `miso_oe_o` is 0, and serial clock and data input changes have no effect. The byte completed after the pause equals the byte that would have been received without it, and the output bits continue from where they stopped.
- R7: Chip select high clears the bit position, any partial byte and the pause. A partial byte produces no strobe.
- R8: After a pause ended by deselection, reselecting with the hold pin still low does not pause. Once the pin has been seen high, a new low level pauses again.
- R9: `busy_o` equals `busy_i` delayed by one system clock cycle, whether or not a pause is active.
- R10: No pause is entered while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| mosi_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause request, active low |
| busy_i | input | 1 | Internal operation in progress |
| tx_byte_i | input | DATA_W | Response byte to shift out |
| rx_byte_o | output | DATA_W | Last complete received byte |
| byte_valid_o | output | 1 | One-cycle strobe per received byte |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for serial data out |
| hold_active_o | output | 1 | Pause in effect |
| busy_o | output | 1 | Registered busy |

## Verification
The assertions assume that each serial clock phase, and the time between any pin change and the next serial clock edge, lasts longer than the synchronizer delay. Under that assumption every edge is seen once and in order. They also assume the serial clock is low whenever chip select falls. The bench holds each serial clock phase for eight system cycles and changes chip select, hold and data only during a low phase, except in the deliberate clock-high hold cases. Even then it waits several cycles before moving the clock.

// File: rtl/serhold_pkg.sv
package serhold_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
    logic hold_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/sh_sync.sv
module sh_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= RST_VAL;
      else     stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/sh_hold_ctrl.sv
module sh_hold_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cs_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic hold_active,
  output logic out_en
);
  logic hold_q, hold_d, armed_q;

  always_comb begin
    hold_d = hold_q;
    if (cs_s)                                  hold_d = 1'b0;
    else if (!hold_q) begin
      if (!hold_n_s && armed_q && !sck_s)      hold_d = 1'b1;
    end else if (hold_n_s && !sck_s)           hold_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      out_en  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      out_en <= !cs_s && !hold_d;
      if (hold_n_s)  armed_q <= 1'b1;
      else if (cs_s) armed_q <= 1'b0;
    end
  end

  assign hold_active = hold_q;

  assert_oe_off_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> !out_en);
  assert_no_hold_deselected_R10: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !hold_q);
  assert_enter_clock_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_q) |-> $past(!sck_s));
  assert_exit_clock_low_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold_q) && !$past(cs_s)) |-> $past(!sck_s));
endmodule

// File: rtl/sh_shifter.sv
module sh_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              hold_active,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic              miso
);
  localparam int              CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_q, cs_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sr, tx_sr;
  logic              rise, fall, sel_start;

  assign rise      = sck_s && !sck_q;
  assign fall      = !sck_s && sck_q;
  assign sel_start = cs_q && !cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (cs_s) begin
        cnt   <= '0;
        rx_sr <= '0;
        tx_sr <= '0;
      end else if (sel_start) begin
        tx_sr <= tx_byte;
      end else if (!hold_active) begin
        if (rise) begin
          rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
          if (cnt == LAST) begin
            cnt        <= '0;
            byte_valid <= 1'b1;
            rx_byte    <= {rx_sr[DATA_W-2:0], mosi_s};
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end else if (fall) begin
          if (cnt == '0) tx_sr <= tx_byte;
          else           tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sr[DATA_W-1];

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
  assert_frozen_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_active && $past(hold_active) && !cs_s && !$past(cs_s)) |-> ($stable(cnt) && $stable(rx_sr) && $stable(tx_sr)));
  assert_no_strobe_deselected_R7: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !byte_valid);
endmodule

// File: rtl/serial_hold_frontend.sv
module serial_hold_frontend #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_n_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              byte_valid_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              hold_active_o,
  output logic              busy_o
);
  import serhold_pkg::*;

  localparam int PIN_W = $bits(pins_t);

  pins_t raw, syn;
  logic  hold_act;
  logic  busy_q;

  assign raw = '{cs_n: cs_n_i, sck: sck_i, mosi: mosi_i, hold_n: hold_n_i};

  sh_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk (clk), .rst (rst), .din (raw), .dout (syn)
  );

  sh_hold_ctrl u_hold (
    .clk (clk), .rst (rst), .cs_s (syn.cs_n), .sck_s (syn.sck),
    .hold_n_s (syn.hold_n), .hold_active (hold_act), .out_en (miso_oe_o)
  );

  sh_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk (clk), .rst (rst), .cs_s (syn.cs_n), .sck_s (syn.sck),
    .mosi_s (syn.mosi), .hold_active (hold_act), .tx_byte (tx_byte_i),
    .rx_byte (rx_byte_o), .byte_valid (byte_valid_o), .miso (miso_o)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_i;
  end

  assign busy_o        = busy_q;
  assign hold_active_o = hold_act;

  assert_busy_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (busy_o == $past(busy_i)));
endmodule

// File: tb/serial_hold_frontend_tb_top.sv
`timescale 1ns/1ps
module serial_hold_frontend_tb_top;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst, cs_n, sck, mosi, hold_n, busy;
  logic [7:0] tx_byte, rx_byte;
  logic byte_valid, miso, miso_oe, hold_active, busy_out;
  int checks = 0, errs = 0, strobes = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_hold_frontend dut_i (
    .clk (clk), .rst (rst), .cs_n_i (cs_n), .sck_i (sck), .mosi_i (mosi),
    .hold_n_i (hold_n), .busy_i (busy), .tx_byte_i (tx_byte),
    .rx_byte_o (rx_byte), .byte_valid_o (byte_valid), .miso_o (miso),
    .miso_oe_o (miso_oe), .hold_active_o (hold_active), .busy_o (busy_out)
  );

  always @(posedge clk) if (byte_valid) strobes++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rise_half(input logic d, inout logic [7:0] cap);
    mosi = d;
    wait_clk(H);
    cap = {cap[6:0], miso};
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic do_bits(input logic [7:0] d, input int hi, input int lo, inout logic [7:0] cap);
    for (int i = hi; i >= lo; i--) begin
      rise_half(d[i], cap);
      sck = 1'b0;
    end
  endtask

  task automatic select(input logic [7:0] tx);
    tx_byte = tx;
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    wait_clk(H);
  endtask

  initial begin
    logic [7:0] cap, a, b, c, d;
    int s0;
    rst = 1; cs_n = 1; sck = 0; mosi = 0; hold_n = 1; busy = 0; tx_byte = '0;
    wait_clk(5);
    rst = 0;
    wait_clk(5);

    check("R7 reset valid", byte_valid, 0);
    check("R7 reset oe", miso_oe, 0);
    check("R7 reset hold", hold_active, 0);
    check("R7 reset rx", rx_byte, 0);

    // R1/R2 sweep: two-byte transfers
    for (int t = 0; t < 16; t++) begin
      a = 8'(t * 73) ^ 8'h5A; b = 8'(t * 37 + 11);
      c = ~a + 8'(t);         d = 8'(t * 29) ^ 8'hC6;
      s0 = strobes;
      select(b);
      check("R2 oe selected", miso_oe, 1);
      cap = '0;
      do_bits(a, 7, 1, cap);
      rise_half(a[0], cap);
      tx_byte = d;
      sck = 1'b0;
      check("R1 byte0", rx_byte, a);
      check("R2 out0", cap, b);
      cap = '0;
      do_bits(c, 7, 0, cap);
      check("R1 byte1", rx_byte, c);
      check("R2 out1", cap, d);
      check("R1 strobes", strobes - s0, 2);
      deselect();
    end

    // R3/R6: hold with clock low
    s0 = strobes; cap = '0;
    select(8'hC3);
    do_bits(8'h96, 7, 5, cap);
    hold_n = 0; wait_clk(6);
    check("R3 hold entered", hold_active, 1);
    check("R6 oe off", miso_oe, 0);
    for (int k = 0; k < 3; k++) begin
      mosi = ~mosi; sck = 1; wait_clk(H); sck = 0; wait_clk(H);
    end
    hold_n = 1; wait_clk(6);
    check("R5 hold left", hold_active, 0);
    check("R2 oe back", miso_oe, 1);
    do_bits(8'h96, 4, 0, cap);
    check("R6 rx kept", rx_byte, 8'h96);
    check("R6 tx kept", cap, 8'hC3);
    check("R6 one strobe", strobes - s0, 1);
    deselect();

    // R4/R5: hold with clock high, release with clock high
    s0 = strobes; cap = '0;
    select(8'h5E);
    do_bits(8'h3B, 7, 5, cap);
    rise_half(8'h3B >> 4 & 1, cap);
    hold_n = 0; wait_clk(6);
    check("R4 deferred", hold_active, 0);
    sck = 0; wait_clk(6);
    check("R4 entered on low", hold_active, 1);
    mosi = ~mosi; sck = 1; wait_clk(H);
    hold_n = 1; wait_clk(6);
    check("R5 exit deferred", hold_active, 1);
    sck = 0; wait_clk(6);
    check("R5 exit on low", hold_active, 0);
    do_bits(8'h3B, 3, 0, cap);
    check("R6 rx after high hold", rx_byte, 8'h3B);
    check("R6 tx after high hold", cap, 8'h5E);
    check("R6 strobe high hold", strobes - s0, 1);
    deselect();

    // R7/R8/R9: deselect in hold, reselect with hold low
    cap = '0;
    select(8'hA1);
    do_bits(8'hFF, 7, 5, cap);
    hold_n = 0; wait_clk(6);
    check("R3 hold before deselect", hold_active, 1);
    busy = 1; wait_clk(3);
    check("R9 busy in hold", busy_out, 1);
    s0 = strobes;
    cs_n = 1; wait_clk(6);
    check("R7 hold cleared", hold_active, 0);
    check("R7 oe off", miso_oe, 0);
    cs_n = 0; wait_clk(6);
    check("R8 no rehold", hold_active, 0);
    check("R8 oe on", miso_oe, 1);
    cap = '0;
    do_bits(8'h6D, 7, 0, cap);
    check("R7 fresh byte", rx_byte, 8'h6D);
    check("R2 fresh out", cap, 8'hA1);
    check("R7 partial discarded", strobes - s0, 1);
    hold_n = 1; wait_clk(6);
    hold_n = 0; wait_clk(6);
    check("R8 rearmed", hold_active, 1);
    hold_n = 1; busy = 0; wait_clk(6);
    check("R9 busy cleared", busy_out, 0);
    deselect();

    // R7: partial byte outside hold
    s0 = strobes; cap = '0;
    select(8'h00);
    do_bits(8'hFF, 7, 3, cap);
    deselect();
    check("R7 no partial strobe", strobes - s0, 0);
    select(8'h00);
    do_bits(8'hE4, 7, 0, cap);
    check("R7 realigned", rx_byte, 8'hE4);
    check("R7 one strobe", strobes - s0, 1);
    deselect();

    // R10: hold ignored while deselected
    hold_n = 0; wait_clk(6);
    check("R10 no hold deselected", hold_active, 0);
    hold_n = 1; wait_clk(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule